// File: doc/BRIEF.md
# I2C Target with SDA Loopback Checking

This block is an I2C target that serves a small byte-wide register bank. Its data line is split in two: `sda_i` carries the wired bus level, and `sda_oe_o` pulls the line low when high and lets it float when low. A fast system clock oversamples SCL and `sda_i` through a synchronizer. The block detects START and STOP, matches its 7-bit device address, acknowledges, and then handles register writes and reads through an internal register port.

While it owns the line, the block compares what it drives with what it reads back. It gives up the bus for the rest of the transaction in two cases: when another device holds the line low while the block has released it during a read, or when its own acknowledge to the address does not appear on `sda_i` within a set window. Either event sets a sticky flag that a controller can read back over I2C.

Once a write address has been acknowledged, the first data byte sets an 8-bit register pointer. Each later byte is stored at the pointer, which then advances. A read sends the byte at the pointer and advances it, and keeps doing so for as long as the controller acknowledges.

Top module: `i2clb_target`

## Requirements
- R1: After reset `sda_oe_o` is 0, and the status byte reads 0x00 until an abort occurs.
- R2: For STARTUP_CYCLES clock cycles after reset is released, all bus traffic is ignored. A correctly addressed transfer receives no acknowledge and the block never drives the line.
- R3: The first byte after START carries the device address in bits 7:1 and the direction in bit 0 (1 = read). The block acknowledges only when the address equals DEV_ADDR. On a mismatch it does not drive the line until the next START.
- R4: The block never starts driving the line while SCL is high. Every change it makes to the line during a transfer happens between HOLD_CYCLES and HOLD_CYCLES+5 clock cycles after SCL falls at the pin.
- R5: In a write, every byte is acknowledged. The first data byte loads the pointer. Each later byte is stored at the pointer, which then increments.
- R6: A read sends the byte at the pointer, MSB first, then increments the pointer. It continues while the controller acknowledges. After a NACK the block stops driving until STOP or START.
- R7: During a read, if the block has released the line but SCL high finds `sda_i` low, the block releases the line for the rest of the transaction and sets status bit 0 (contention).
- R8: If `sda_i` does not go low within ECHO_CYCLES clock cycles of the block pulling the line low to acknowledge its address, the block releases the line, ignores the rest of the transaction and sets status bit 1 (echo missing).
- R9: The status byte is at pointer STAT_ADDR (0xF0). Bit 0 is the contention flag and bit 1 the echo-missing flag; the upper bits are 0. Both flags are sticky until reset, and writes to STAT_ADDR are ignored.
- R10: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are recognised in every state. A repeated START begins a new address phase.
- R11: The pointer is 8 bits wide and wraps from 0xFF to 0x00. Pointers at or above REG_DEPTH, other than STAT_ADDR, read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the bus |
| sda_i | input | 1 | SDA level read back from the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest conditions to create are the two loopback failures. In a correct circuit the read-back line always follows the block's own drive, so neither failure can happen on its own. The bench models the wire as an AND of the controller, the block and a fault source. A contention fault is injected by holding the line low during a read byte that begins with a 1 bit. A missing echo is injected by cutting the block's drive out of the `sda_i` path while the controller still sees the real bus. After each fault the bench confirms that the line stays released, then reads the status byte to check which sticky flag was set.

// File: rtl/i2clb_pkg.sv
package i2clb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } tgt_state_e;

  typedef struct packed {
    logic echo_miss;
    logic contention;
  } tgt_flags_t;

endpackage

// File: rtl/i2clb_sync.sv
module i2clb_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-1:0], raw_i[g]};
    end

    assign level_o[g] = chain[STAGES-1];
    assign rise_o[g]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g]  = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/i2clb_drive.sv
module i2clb_drive #(
  parameter int unsigned HOLD_CYCLES = 27
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_fall_i,
  input  logic scl_high_i,
  input  logic want_low_i,
  input  logic release_i,
  output logic oe_o
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o <= 1'b0;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (release_i) begin
      oe_o <= 1'b0;
      pend <= 1'b0;
    end else if (scl_fall_i) begin
      cnt  <= CW'(HOLD_CYCLES);
      pend <= 1'b1;
    end else if (pend) begin
      if (cnt == '0) begin
        oe_o <= want_low_i;
        pend <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R4: never begin pulling the line while SCL stays high
  p_no_grab_scl_high_r4: assert property (@(posedge clk) disable iff (rst)
    (scl_high_i && $past(scl_high_i)) |-> !$rose(oe_o));

endmodule

// File: rtl/i2clb_regfile.sv
module i2clb_regfile #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  STAT_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [7:0]        waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [7:0]        raddr_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] stat_q;
  logic              sel_mem;
  logic              sel_stat;
  logic              w_in;
  logic              r_in;

  assign w_in = (waddr_i != STAT_ADDR) && (int'(waddr_i) < DEPTH);
  assign r_in = int'(raddr_i) < DEPTH;

  always_ff @(posedge clk) begin
    if (we_i && w_in) mem[waddr_i[IDX_W-1:0]] <= wdata_i;
    mem_q <= mem[raddr_i[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_mem  <= 1'b0;
      sel_stat <= 1'b0;
      stat_q   <= '0;
    end else begin
      sel_stat <= (raddr_i == STAT_ADDR);
      sel_mem  <= r_in;
      stat_q   <= status_i;
    end
  end

  always_comb begin
    if (sel_stat)     rdata_o = stat_q;
    else if (sel_mem) rdata_o = mem_q;
    else              rdata_o = '0;
  end

endmodule

// File: rtl/i2clb_target.sv
module i2clb_target
  import i2clb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR       = 7'h2A,
  parameter int unsigned REG_DEPTH      = 16,
  parameter logic [7:0]  STAT_ADDR      = 8'hF0,
  parameter int unsigned STARTUP_CYCLES = 500000,
  parameter int unsigned HOLD_CYCLES    = 27,
  parameter int unsigned ECHO_CYCLES    = 60,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam int unsigned SU_W   = $clog2(STARTUP_CYCLES + 1);
  localparam int unsigned EC_W   = $clog2(ECHO_CYCLES + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  // synchronized bus
  logic [1:0] lvl, rse, fll;
  logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;

  i2clb_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_i   ({sda_i, scl_i}),
    .level_o (lvl),
    .rise_o  (rse),
    .fall_o  (fll)
  );

  assign scl_s    = lvl[0];
  assign sda_s    = lvl[1];
  assign scl_rise = rse[0];
  assign scl_fall = fll[0];
  assign sda_rise = rse[1];
  assign sda_fall = fll[1];

  // startup quiet period
  logic [SU_W-1:0] su_cnt;
  logic            ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      su_cnt <= '0;
      ready  <= 1'b0;
    end else if (!ready) begin
      if (su_cnt == SU_W'(STARTUP_CYCLES - 1)) ready <= 1'b1;
      else                                     su_cnt <= su_cnt + 1'b1;
    end
  end

  // protocol state
  tgt_state_e        state;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [7:0]        ptr;
  logic              rw;
  logic              first_q;
  logic              echo_ok;
  logic [EC_W-1:0]   echo_cnt;
  tgt_flags_t        flags;
  logic [BYTE_W-1:0] rd_data;

  logic [BYTE_W-1:0] byte_in;
  logic start_ev, stop_ev, echo_fail, contend, release_now, want_low, wr_commit;

  assign byte_in  = {shreg[BYTE_W-2:0], sda_s};
  assign start_ev = ready && scl_s && sda_fall;
  assign stop_ev  = ready && scl_s && sda_rise;

  assign echo_fail = (state == ST_AACK) &&
                     ((sda_oe_o && !echo_ok && sda_s && echo_cnt == EC_W'(ECHO_CYCLES - 1)) ||
                      (scl_rise && !echo_ok));

  assign contend = (state == ST_RBYTE) && scl_rise && !sda_oe_o && !sda_s;

  assign release_now = start_ev || stop_ev || echo_fail || contend;

  assign wr_commit = !start_ev && !stop_ev && (state == ST_WBYTE) &&
                     scl_rise && (bitcnt == LAST_BIT) && !first_q;

  always_comb begin
    unique case (state)
      ST_AACK, ST_WACK: want_low = 1'b1;
      ST_RBYTE:         want_low = ~txreg[LAST_BIT - bitcnt];
      default:          want_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      first_q  <= 1'b0;
      echo_ok  <= 1'b0;
      echo_cnt <= '0;
      flags    <= '0;
    end else if (start_ev) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: if (scl_rise) begin
          shreg  <= byte_in;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            if (shreg[6:0] == DEV_ADDR) begin
              rw       <= sda_s;
              state    <= ST_AACK;
              echo_ok  <= 1'b0;
              echo_cnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (echo_fail) begin
            flags.echo_miss <= 1'b1;
            state           <= ST_IDLE;
          end else begin
            if (sda_oe_o && !echo_ok) begin
              if (!sda_s) echo_ok  <= 1'b1;
              else        echo_cnt <= echo_cnt + 1'b1;
            end
            if (scl_rise) begin
              bitcnt <= '0;
              if (rw) begin
                txreg <= rd_data;
                ptr   <= ptr + 1'b1;
                state <= ST_RBYTE;
              end else begin
                first_q <= 1'b1;
                state   <= ST_WBYTE;
              end
            end
          end
        end
        ST_WBYTE: if (scl_rise) begin
          shreg  <= byte_in;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            state <= ST_WACK;
            if (first_q) begin
              ptr     <= byte_in;
              first_q <= 1'b0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        ST_WACK: if (scl_rise) begin
          bitcnt <= '0;
          state  <= ST_WBYTE;
        end
        ST_RBYTE: begin
          if (contend) begin
            flags.contention <= 1'b1;
            state            <= ST_IDLE;
          end else if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) state <= ST_RACK;
          end
        end
        ST_RACK: if (scl_rise) begin
          if (!sda_s) begin
            txreg  <= rd_data;
            ptr    <= ptr + 1'b1;
            bitcnt <= '0;
            state  <= ST_RBYTE;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  i2clb_drive #(.HOLD_CYCLES(HOLD_CYCLES)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .scl_fall_i (scl_fall),
    .scl_high_i (scl_s),
    .want_low_i (want_low),
    .release_i  (release_now),
    .oe_o       (sda_oe_o)
  );

  i2clb_regfile #(
    .DEPTH     (REG_DEPTH),
    .DATA_W    (BYTE_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we_i     (wr_commit),
    .waddr_i  (ptr),
    .wdata_i  (byte_in),
    .raddr_i  (ptr),
    .status_i ({6'd0, flags}),
    .rdata_o  (rd_data)
  );

  // R2: quiet until the startup window has elapsed
  p_quiet_startup_r2: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (state == ST_IDLE) && !sda_oe_o);

  // R3: a target that is not engaged leaves the line alone
  p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe_o);

  // R5: each stored byte advances the pointer by one
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> ptr == 8'($past(ptr) + 8'd1));

  // R7: contention drops the line at once and the flag stays set
  p_contend_drop_r7: assert property (@(posedge clk) disable iff (rst)
    contend |=> !sda_oe_o && flags.contention);
  p_contend_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    flags.contention |=> flags.contention);

  // R8: a missing acknowledge echo abandons the transfer
  p_echo_drop_r8: assert property (@(posedge clk) disable iff (rst)
    echo_fail |=> !sda_oe_o && (state == ST_IDLE) && flags.echo_miss);

  // R10: START always restarts the address phase with the line free
  p_start_restart_r10: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_ADDR) && !sda_oe_o);

endmodule

// File: tb/i2clb_target_tb_top.sv
module i2clb_target_tb_top;

  localparam logic [6:0] DEV     = 7'h2A;
  localparam int         DEPTH   = 16;
  localparam logic [7:0] STAT    = 8'hF0;
  localparam int         STARTUP = 3000;
  localparam int         HOLD    = 27;
  localparam int         ECHO    = 40;

  typedef logic [7:0] bytes_t [16];

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl = 1'b1, host_sda = 1'b1, fault_low = 1'b0, echo_broken = 1'b0;
  logic sda_oe;
  logic bus, sda_in;
  assign bus    = host_sda & ~sda_oe & ~fault_low;
  assign sda_in = echo_broken ? (host_sda & ~fault_low) : bus;

  i2clb_target #(
    .DEV_ADDR(DEV), .REG_DEPTH(DEPTH), .STAT_ADDR(STAT),
    .STARTUP_CYCLES(STARTUP), .HOLD_CYCLES(HOLD), .ECHO_CYCLES(ECHO), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_in), .sda_oe_o(sda_oe)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] stat_m = 8'h00;

  // monitor, sampled 2 ns after each rising edge
  int  oe_total = 0, since_fall = 0, dmin = 1000, dmax = 0, dcount = 0;
  bit  mon_en = 1'b0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(posedge clk) begin
    #2;
    if (scl_prev && !scl) since_fall = 0;
    else                  since_fall = since_fall + 1;
    if (sda_oe) oe_total = oe_total + 1;
    if (mon_en && (sda_oe != oe_prev) && !scl) begin
      dcount = dcount + 1;
      if (since_fall < dmin) dmin = since_fall;
      if (since_fall > dmax) dmax = since_fall;
    end
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    if (p == STAT)          return stat_m;
    else if (int'(p) < DEPTH) return mem_m[p[3:0]];
    else                    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(20);
    scl = 1'b1;      tick(40);
    host_sda = 1'b0; tick(40);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(20);
    scl = 1'b1;      tick(40);
    host_sda = 1'b1; tick(40);
  endtask

  task automatic wbit(input logic b);
    tick(10); host_sda = b;
    tick(60); scl = 1'b1;
    tick(60); scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    host_sda = 1'b1;
    tick(70); scl = 1'b1;
    tick(30); b = bus;
    tick(30); scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack);
  endtask

  task automatic rbyte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(nack);
  endtask

  task automatic do_write(input logic [7:0] p0, input int n, input bytes_t d, input string tag);
    logic ack;
    logic [7:0] p;
    p = p0;
    bus_start();
    wbyte({DEV, 1'b0}, ack); chk(ack == 1'b0, {tag, " R3 addr ack"}, ack, 0);
    wbyte(p0, ack);          chk(ack == 1'b0, {tag, " R5 ptr ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      wbyte(d[i], ack);      chk(ack == 1'b0, {tag, " R5 data ack"}, ack, 0);
      if (p != STAT && int'(p) < DEPTH) mem_m[p[3:0]] = d[i];
      p = p + 8'd1;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] p0, input int n, input string tag);
    logic ack;
    logic [7:0] p, v;
    p = p0;
    bus_start();
    wbyte({DEV, 1'b0}, ack); chk(ack == 1'b0, {tag, " R3 addr ack"}, ack, 0);
    wbyte(p0, ack);          chk(ack == 1'b0, {tag, " R5 ptr ack"}, ack, 0);
    bus_start();
    wbyte({DEV, 1'b1}, ack); chk(ack == 1'b0, {tag, " R10 rstart ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(v, (i == n - 1));
      chk(v == exp_rd(p), {tag, " R6 read data"}, v, exp_rd(p));
      p = p + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bytes_t d;
    logic ack, ack2, b;
    logic [7:0] v;
    int base;
    void'($urandom(32'h5EED1234));
    tick(10);
    rst = 1'b0;
    tick(2);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R2: addressed traffic inside the startup window is ignored
    base = oe_total;
    bus_start();
    wbyte({DEV, 1'b0}, ack); chk(ack == 1'b1, "R2 no ack during startup", ack, 1);
    wbyte(8'h04, ack);       chk(ack == 1'b1, "R2 no data ack during startup", ack, 1);
    bus_stop();
    chk(oe_total == base, "R2 line never driven", oe_total - base, 0);
    tick(STARTUP);

    // R1: status clear after reset
    do_read(STAT, 1, "R1 status");

    // initialise the register bank (R5)
    for (int i = 0; i < DEPTH; i++) d[i] = 8'($urandom_range(0, 255));
    do_write(8'h00, DEPTH, d, "R5 init burst");

    // R4 + R6: timed read burst
    mon_en = 1'b1;
    do_read(8'h00, 3, "R6 burst");
    mon_en = 1'b0;
    chk(dcount > 0, "R4 drive changes seen", dcount, 1);
    chk(dmin >= HOLD && dmax <= HOLD + 5, "R4 hold delay", dmin * 1000 + dmax, HOLD);

    // random mix of writes and reads (R5, R6)
    for (int t = 0; t < 6; t++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom_range(0, DEPTH - 1));
      n = $urandom_range(1, 4);
      if ($urandom_range(0, 1) == 1) begin
        for (int i = 0; i < n; i++) d[i] = 8'($urandom_range(0, 255));
        do_write(p, n, d, "R5 random write");
      end else begin
        do_read(p, n, "R6 random read");
      end
    end

    // R6: after NACK the target stays off the line
    bus_start();
    wbyte({DEV, 1'b0}, ack); wbyte(8'h02, ack);
    bus_start();
    wbyte({DEV, 1'b1}, ack);
    rbyte(v, 1'b1); chk(v == mem_m[2], "R6 nack byte", v, mem_m[2]);
    base = oe_total;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    chk(v == 8'hFF, "R6 released after nack", v, 8'hFF);
    chk(oe_total == base, "R6 no drive after nack", oe_total - base, 0);
    bus_stop();

    // R3: address mismatch
    base = oe_total;
    bus_start();
    wbyte({7'h15, 1'b0}, ack); chk(ack == 1'b1, "R3 mismatch no ack", ack, 1);
    wbyte(8'h00, ack);         chk(ack == 1'b1, "R3 mismatch data ignored", ack, 1);
    bus_stop();
    chk(oe_total == base, "R3 mismatch never drives", oe_total - base, 0);

    // R11: pointer wrap and out-of-range addresses
    d[0] = 8'h11; d[1] = 8'h5A;
    do_write(8'hFF, 2, d, "R11 wrap write");
    do_read(8'hFF, 2, "R11 wrap read");
    do_read(8'h20, 1, "R11 out of range");

    // R7: contention during a read
    d[0] = 8'hC3;
    do_write(8'h05, 1, d, "R7 setup");
    bus_start();
    wbyte({DEV, 1'b0}, ack); wbyte(8'h05, ack);
    bus_start();
    wbyte({DEV, 1'b1}, ack); chk(ack == 1'b0, "R7 read addr ack", ack, 0);
    fault_low = 1'b1;
    rbit(b);
    base = oe_total;
    for (int i = 0; i < 7; i++) rbit(b);
    wbit(1'b1);
    fault_low = 1'b0;
    for (int i = 0; i < 8; i++) rbit(b);
    chk(oe_total == base, "R7 released after contention", oe_total - base, 0);
    bus_stop();
    stat_m = stat_m | 8'h01;
    do_read(STAT, 1, "R7 R9 status contention");

    // R9: status is read-only
    d[0] = 8'h00;
    do_write(STAT, 1, d, "R9 status write");
    do_read(STAT, 1, "R9 status unchanged");

    // R8: acknowledge echo missing
    echo_broken = 1'b1;
    bus_start();
    wbyte({DEV, 1'b0}, ack); chk(ack == 1'b1, "R8 echo abort visible", ack, 1);
    base = oe_total;
    wbyte(8'h07, ack2);      chk(ack2 == 1'b1, "R8 rest of transfer ignored", ack2, 1);
    chk(oe_total == base, "R8 no drive after abort", oe_total - base, 0);
    bus_stop();
    echo_broken = 1'b0;
    stat_m = stat_m | 8'h02;
    do_read(STAT, 1, "R8 R9 status echo");

    // R10: normal service resumes
    d[0] = 8'h3C; d[1] = 8'hE7;
    do_write(8'h09, 2, d, "R10 resume write");
    do_read(8'h09, 2, "R10 resume read");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule